// File: doc/BRIEF.md
# Sticky Video Error Status Aggregator

This block gathers single-cycle error indications from the stages of a serial video receive pipeline and latches each into its own bit of a status word. A bit stays set until either the video timing announces a new frame or field, or the host reads the status word. Both events clear every bit at once.

A mask word chooses which error classes take part in a combined error flag. That flag is active low and is the inverted OR of the monitored status bits. It is registered on the pixel clock, so it changes on the same edge as the status word. All inputs and outputs are plain control or status signals. No data stream passes through the block, so there is no valid/ready handshake.

Top module: `vid_err_status`

## Requirements
- R1: Each error class owns one status bit. The bit positions are: 0 lock loss, 1 ancillary checksum, 2 start-of-active-video timing reference, 3 end-of-active-video timing reference, 4 active-picture CRC, 5 full-field CRC, 6 illegal code remapped. A high pulse on `err_evt[i]` at a rising edge sets `status[i]` from that edge onward.
- R2: A set status bit stays set on every later edge until a clear event occurs.
- R3: `frame_start` high at an edge clears every status bit at that edge.
- R4: While `status_rd` is high, `status` still shows the uncleared value. The clear takes effect at the edge that samples `status_rd`, so the word is zero in the following cycle.
- R5: An `err_evt[i]` pulse at the same edge as a clear event leaves `status[i]` set, so no error is lost.
- R6: `err_n` is low exactly when some status bit is set whose mask bit is 1. It updates on the same edge as `status`.
- R7: A mask bit of 1 means the class is monitored and a 0 removes it from `err_n`. A masked class is still recorded in `status`. `mask_we` loads `mask_wdata` at the edge, and the new mask governs `err_n` from that edge onward.
- R8: An active-low `rst_n` asynchronously clears `status` and sets every mask bit to 1. While reset is asserted, `err_n` keeps the value it had.
- R9: `err_n` is high whenever no monitored status bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Parallel pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| err_evt | input | 7 | Per-class error pulses, positions as in R1 |
| frame_start | input | 1 | Frame or field boundary strobe; clears status |
| status_rd | input | 1 | Host read strobe for the status word |
| mask_we | input | 1 | Load strobe for the mask word |
| mask_wdata | input | 7 | New mask, 1 = class monitored |
| status | output | 7 | Sticky status word |
| err_n | output | 1 | Active-low combined error flag |

## Verification
The assertions check four things on every cycle. They check that a pulse always lands in its bit and that a set bit survives until a clear. They check that a clear without a coinciding pulse empties the bit. They check that `err_n` always agrees with the masked status word once reset has been released. Some behaviour can only be shown by the bench's scenarios. This includes the value seen during a read, where the status is observed before and after the clearing edge. It also includes the hold of `err_n` across an active reset and the reset value of the mask, which the bench reveals through `err_n`. Finally, it includes the precise edge at which a mask write takes effect.

// File: rtl/vid_err_pkg.sv
package vid_err_pkg;
  localparam int ERR_CLASSES = 7;

  typedef enum int unsigned {
    ERR_LOCK     = 0,
    ERR_ANC_CSUM = 1,
    ERR_SAV      = 2,
    ERR_EAV      = 3,
    ERR_AP_CRC   = 4,
    ERR_FF_CRC   = 5,
    ERR_REMAP    = 6
  } err_class_e;
endpackage

// File: rtl/err_capture_bank.sv
module err_capture_bank #(
  parameter int N = vid_err_pkg::ERR_CLASSES
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] evt,
  input  logic         clr,
  output logic [N-1:0] flags_q,
  output logic [N-1:0] flags_d
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    // R5: an event that coincides with a clear wins
    always_comb flags_d[i] = evt[i] | (flags_q[i] & ~clr);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flags_q[i] <= 1'b0;
      else        flags_q[i] <= flags_d[i];
    end

    p_capture_r1: assert property (@(posedge clk) disable iff (!rst_n)
      evt[i] |=> flags_q[i]);
    p_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (flags_q[i] && !clr) |=> flags_q[i]);
    p_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && !evt[i]) |=> !flags_q[i]);
  end
endmodule

// File: rtl/err_mask_reg.sv
module err_mask_reg #(
  parameter int N = vid_err_pkg::ERR_CLASSES
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we,
  input  logic [N-1:0] wdata,
  output logic [N-1:0] mask_q,
  output logic [N-1:0] mask_d
);
  localparam logic [N-1:0] MONITOR_ALL = '1;

  always_comb mask_d = we ? wdata : mask_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mask_q <= MONITOR_ALL;
    else        mask_q <= mask_d;
  end

  // R7: a written mask is held until the next write
  p_mask_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(mask_q));
endmodule

// File: rtl/err_flag_combiner.sv
module err_flag_combiner #(
  parameter int N = vid_err_pkg::ERR_CLASSES
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] flags_d,
  input  logic [N-1:0] mask_d,
  input  logic [N-1:0] flags_q,
  input  logic [N-1:0] mask_q,
  output logic         err_n
);
  logic err_n_q;

  // R8: no reset term, so the flag keeps its value while reset is held
  always_ff @(posedge clk) begin
    if (rst_n) err_n_q <= ~|(flags_d & mask_d);
  end

  assign err_n = err_n_q;

  p_combined_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (err_n == ~|(flags_q & mask_q)));
endmodule

// File: rtl/vid_err_status.sv
module vid_err_status #(
  parameter int N = vid_err_pkg::ERR_CLASSES
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] err_evt,
  input  logic         frame_start,
  input  logic         status_rd,
  input  logic         mask_we,
  input  logic [N-1:0] mask_wdata,
  output logic [N-1:0] status,
  output logic         err_n
);
  logic         clr;
  logic [N-1:0] flags_q, flags_d, mask_q, mask_d;

  // R3/R4: either boundary or host read clears at this edge
  assign clr = frame_start | status_rd;

  err_capture_bank #(.N(N)) u_bank (
    .clk(clk), .rst_n(rst_n), .evt(err_evt), .clr(clr),
    .flags_q(flags_q), .flags_d(flags_d)
  );

  err_mask_reg #(.N(N)) u_mask (
    .clk(clk), .rst_n(rst_n), .we(mask_we), .wdata(mask_wdata),
    .mask_q(mask_q), .mask_d(mask_d)
  );

  err_flag_combiner #(.N(N)) u_comb (
    .clk(clk), .rst_n(rst_n), .flags_d(flags_d), .mask_d(mask_d),
    .flags_q(flags_q), .mask_q(mask_q), .err_n(err_n)
  );

  assign status = flags_q;
endmodule

// File: tb/sim_vid_err_status.sv
module sim_vid_err_status;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 13;
  // {evt[6:0], frame_start, status_rd, mask_we, mask_wdata[6:0], exp_status[6:0], exp_err_n}
  localparam logic [24:0] VECS [NV] = '{
    {7'h01, 1'b0, 1'b0, 1'b0, 7'h00, 7'h01, 1'b0}, // R1 R6 lock bit 0
    {7'h00, 1'b0, 1'b0, 1'b0, 7'h00, 7'h01, 1'b0}, // R2 sticky
    {7'h00, 1'b1, 1'b0, 1'b0, 7'h00, 7'h00, 1'b1}, // R3 R9 frame clear
    {7'h20, 1'b0, 1'b0, 1'b0, 7'h00, 7'h20, 1'b0}, // R1 full-field bit 5
    {7'h00, 1'b0, 1'b1, 1'b0, 7'h00, 7'h00, 1'b1}, // R4 read clear
    {7'h04, 1'b1, 1'b0, 1'b0, 7'h00, 7'h04, 1'b0}, // R5 event with frame clear
    {7'h00, 1'b0, 1'b0, 1'b1, 7'h7B, 7'h04, 1'b1}, // R7 unmonitor bit 2
    {7'h08, 1'b0, 1'b0, 1'b0, 7'h00, 7'h0C, 1'b0}, // R6 bit 3 monitored
    {7'h00, 1'b1, 1'b0, 1'b0, 7'h00, 7'h00, 1'b1}, // R3
    {7'h04, 1'b0, 1'b0, 1'b0, 7'h00, 7'h04, 1'b1}, // R7 masked still recorded
    {7'h00, 1'b0, 1'b0, 1'b1, 7'h7F, 7'h04, 1'b0}, // R7 re-monitor
    {7'h40, 1'b0, 1'b1, 1'b0, 7'h00, 7'h40, 1'b0}, // R5 event with read
    {7'h00, 1'b0, 1'b1, 1'b0, 7'h00, 7'h00, 1'b1}  // R4 R9
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [6:0] err_evt = '0;
  logic       frame_start = 1'b0;
  logic       status_rd = 1'b0;
  logic       mask_we = 1'b0;
  logic [6:0] mask_wdata = '0;
  logic [6:0] status;
  logic       err_n;
  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vid_err_status u0 (
    .clk(clk), .rst_n(rst_n), .err_evt(err_evt), .frame_start(frame_start),
    .status_rd(status_rd), .mask_we(mask_we), .mask_wdata(mask_wdata),
    .status(status), .err_n(err_n)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    err_evt = '0; frame_start = 1'b0; status_rd = 1'b0; mask_we = 1'b0; mask_wdata = '0;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    @(posedge clk); #1;
    check("R8 status after reset", {1'b0, status}, 8'h00);
    check("R9 err_n idle", {7'h0, err_n}, 8'h01);

    for (int v = 0; v < NV; v++) begin
      @(negedge clk);
      {err_evt, frame_start, status_rd, mask_we, mask_wdata} = VECS[v][24:8];
      @(posedge clk); #1;
      check($sformatf("vector %0d status", v), {1'b0, status}, {1'b0, VECS[v][7:1]});
      check($sformatf("vector %0d err_n", v), {7'h0, err_n}, {7'h0, VECS[v][0]});
      idle();
    end

    // R4: status visible during the read cycle, gone afterwards
    @(negedge clk) err_evt = 7'h12;
    @(negedge clk) begin idle(); status_rd = 1'b1; end
    #1 check("R4 value during read", {1'b0, status}, 8'h12);
    @(posedge clk); #1;
    check("R4 cleared after read", {1'b0, status}, 8'h00);
    @(negedge clk) idle();

    // R8: err_n held during reset, status cleared, mask restored
    @(negedge clk) mask_we = 1'b1;  // mask_wdata = 0 masks all
    @(negedge clk) begin idle(); err_evt = 7'h02; end
    @(posedge clk); #1;
    check("R7 all masked", {7'h0, err_n}, 8'h01);
    @(negedge clk) begin idle(); mask_we = 1'b1; mask_wdata = 7'h7F; end
    @(posedge clk); #1;
    check("R6 remonitored", {7'h0, err_n}, 8'h00);
    @(negedge clk) begin idle(); rst_n = 1'b0; end
    @(posedge clk); #1;
    check("R8 status in reset", {1'b0, status}, 8'h00);
    check("R8 err_n held in reset", {7'h0, err_n}, 8'h00);
    @(negedge clk) mask_wdata = 7'h00;
    @(negedge clk) rst_n = 1'b1;
    @(posedge clk); #1;
    check("R9 err_n after reset", {7'h0, err_n}, 8'h01);
    @(negedge clk) err_evt = 7'h40;
    @(posedge clk); #1;
    check("R8 mask reset monitors bit 6", {7'h0, err_n}, 8'h00);
    @(negedge clk) idle();

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule